// File: doc/BRIEF.md
# Reset Cause Controller

This block gathers the reset requests of a small chip into a single system reset and remembers which of them started the most recent reset. Three sources are merged. The first is an active-low external pin. The second is a supply monitor, whose comparator output arrives as a digital "supply good" level. The third is a missing-clock detector. It runs on a free-running reference clock and measures how long the system clock sits at one level.

Software reaches two byte-wide registers through a simple write-strobe and read-mux interface. The monitor control register holds the monitor enable, the threshold select and a live copy of the supply status. The reset-source register holds the cause flags, the monitor source select and the missing-clock bit. The missing-clock bit is both the detector enable and the detector's cause flag.

The system reset is held for a fixed number of reference cycles after the last request goes away. Only one cause is recorded per reset event.

Top module: `rcc_top`

## Requirements
- R1: While `porN` is low, `sysRst` is high. After `porN` is released, `sysRst` is low. The reset-source register (address 1) reads 0x00. The monitor control register (address 0) reads 0x80 with bit 6 equal to the synchronized `supplyOk`.
- R2: A low `extRstN` raises `sysRst` within 3 reference cycles and keeps it high while the pin stays low. After the pin rises, `sysRst` stays high for exactly STRETCH_CYC+2 more reference cycles, two of which are synchronizer delay.
- R3: A reset started by the pin sets bit 0 of the reset-source register and clears bits 2 and 3. Clearing bit 2 disables the missing-clock detector.
- R4: The supply monitor starts a reset only when monitor enable (address 0, bit 7) and source select (address 1, bit 1) are both 1 and `supplyOk` is low. Such a reset sets bit 3 and clears bits 0 and 2.
- R5: With bit 2 of address 1 at 1, a system-clock level lasting more than MCD_LIMIT reference cycles starts a reset. Levels of at most MCD_LIMIT cycles never do.
- R6: After a missing-clock reset, bit 2 of address 1 reads 1 and bits 0 and 3 read 0.
- R7: When several sources request at once, only one flag is recorded. The pin wins over the supply monitor, and the supply monitor wins over the missing clock.
- R8: At address 0, bit 7 (enable) and bit 5 (level select, driven on `monLevelHigh`) are read/write. Bit 6 is read-only supply status. Bits 4:0 read 0.
- R9: At address 1, bits 1 and 2 are read/write. Bits 0 and 3 ignore writes. Bits 7:4 read 0.
- R10: Requests that arrive while `sysRst` is already high extend the reset but leave the recorded cause unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Free-running reference clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| extRstN | input | 1 | External reset pin, active low |
| supplyOk | input | 1 | Supply comparator output, 1 = above threshold |
| sysClk | input | 1 | System clock being watched |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 monitor control, 1 reset source |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the selected register |
| monLevelHigh | output | 1 | Threshold select to the comparator |
| sysRst | output | 1 | System reset, active high |

## Verification
The bench builds the block with MCD_LIMIT = 6 and STRETCH_CYC = 4. With those values the bench can sweep every system-clock half-period from 1 to 10 reference cycles. That sweep covers both sides of the detector's limit, including the exact boundary at 6 and 7. The short stretch lets the release cycle be counted exactly after every reset. Priority and cause retention are exercised by overlapping the pin and supply requests.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  typedef enum logic [1:0] {CAUSE_NONE, CAUSE_PIN, CAUSE_SUP, CAUSE_MCD} cause_e;
  typedef enum logic {ST_IDLE, ST_HOLD} rstState_e;

  typedef struct packed {
    logic   latchCause;
    cause_e cause;
    logic   loadStretch;
    logic   decStretch;
  } ctlStrobe_t;

  localparam logic REG_MON = 1'b0;
  localparam logic REG_SRC = 1'b1;
endpackage

// File: rtl/rcc_sync.sv
module rcc_sync #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RST_VAL}};
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rcc_control.sv
module rcc_control
  import rcc_pkg::*;
(
  input  logic       refClk,
  input  logic       porN,
  input  logic       pinReq,
  input  logic       supReq,
  input  logic       mcdReq,
  input  logic       stretchDone,
  output ctlStrobe_t strobe,
  output logic       holdRst
);
  rstState_e state, nextState;
  logic      anyReq;
  cause_e    causeSel;

  always_comb begin
    anyReq = pinReq | supReq | mcdReq;
    if (pinReq)      causeSel = CAUSE_PIN;
    else if (supReq) causeSel = CAUSE_SUP;
    else if (mcdReq) causeSel = CAUSE_MCD;
    else             causeSel = CAUSE_NONE;

    strobe       = '0;
    strobe.cause = causeSel;
    nextState    = state;
    case (state)
      ST_IDLE: if (anyReq) begin
        strobe.latchCause  = 1'b1;
        strobe.loadStretch = 1'b1;
        nextState          = ST_HOLD;
      end
      ST_HOLD: begin
        if (anyReq)           strobe.loadStretch = 1'b1;
        else if (stretchDone) nextState = ST_IDLE;
        else                  strobe.decStretch = 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge refClk or negedge porN) begin
    if (!porN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign holdRst = (state == ST_HOLD);

  // R2: a pin request always leaves the block in reset on the next cycle
  p_pin_holds_r2: assert property (@(posedge refClk) disable iff (!porN)
    pinReq |=> holdRst);
  // R2: reset is only released once the stretch ran out with no request
  p_release_after_stretch_r2: assert property (@(posedge refClk) disable iff (!porN)
    $fell(holdRst) |-> ($past(stretchDone) && !$past(anyReq)));
  // R10: no second cause capture while reset is already held
  p_no_relatch_r10: assert property (@(posedge refClk) disable iff (!porN)
    holdRst |-> !strobe.latchCause);
endmodule

// File: rtl/rcc_datapath.sv
module rcc_datapath
  import rcc_pkg::*;
#(
  parameter int MCD_LIMIT   = 64,
  parameter int STRETCH_CYC = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       refClk,
  input  logic       porN,
  input  logic       extRstN,
  input  logic       supplyOk,
  input  logic       sysClk,
  input  logic       wrEn,
  input  logic       regAddr,
  input  logic [7:0] wrData,
  input  ctlStrobe_t strobe,
  output logic       pinReq,
  output logic       supReq,
  output logic       mcdReq,
  output logic       stretchDone,
  output logic [7:0] rdData,
  output logic       monLevelHigh
);
  localparam int CW = $clog2(MCD_LIMIT + 1);
  localparam int SW = $clog2(STRETCH_CYC + 1);
  localparam logic [CW-1:0] MCD_MAX  = CW'(MCD_LIMIT);
  localparam logic [SW-1:0] STR_LOAD = SW'(STRETCH_CYC);

  logic pinLvl, supOkS, sysClkS, sysClkPrev, clkEdge;
  logic [CW-1:0] mcdCnt;
  logic [SW-1:0] stretchCnt;
  logic monEn, monLvl, monSel, mcdEn, pinFlag, supFlag;
  logic unusedWr;

  rcc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) pinSync_i (
    .clk(refClk), .rstN(porN), .d(extRstN), .q(pinLvl));
  rcc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) supSync_i (
    .clk(refClk), .rstN(porN), .d(supplyOk), .q(supOkS));
  rcc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) clkSync_i (
    .clk(refClk), .rstN(porN), .d(sysClk), .q(sysClkS));

  assign clkEdge = sysClkS ^ sysClkPrev;
  assign pinReq  = ~pinLvl;
  assign supReq  = monEn & monSel & ~supOkS;
  assign mcdReq  = mcdEn & (mcdCnt == MCD_MAX);
  assign stretchDone = (stretchCnt == '0);

  // missing-clock level timer
  always_ff @(posedge refClk or negedge porN) begin
    if (!porN) begin
      sysClkPrev <= 1'b0;
      mcdCnt     <= '0;
    end else begin
      sysClkPrev <= sysClkS;
      if (!mcdEn || clkEdge)  mcdCnt <= '0;
      else if (mcdCnt != MCD_MAX) mcdCnt <= mcdCnt + 1'b1;
    end
  end

  // reset stretch counter
  always_ff @(posedge refClk or negedge porN) begin
    if (!porN)                                  stretchCnt <= '0;
    else if (strobe.loadStretch)                stretchCnt <= STR_LOAD;
    else if (strobe.decStretch && !stretchDone) stretchCnt <= stretchCnt - 1'b1;
  end

  // registers and cause flags
  always_ff @(posedge refClk or negedge porN) begin
    if (!porN) begin
      monEn   <= 1'b1;
      monLvl  <= 1'b0;
      monSel  <= 1'b0;
      mcdEn   <= 1'b0;
      pinFlag <= 1'b0;
      supFlag <= 1'b0;
    end else begin
      if (wrEn && regAddr == REG_MON) begin
        monEn  <= wrData[7];
        monLvl <= wrData[5];
      end
      if (wrEn && regAddr == REG_SRC) begin
        monSel <= wrData[1];
        mcdEn  <= wrData[2];
      end
      if (strobe.latchCause) begin
        pinFlag <= (strobe.cause == CAUSE_PIN);
        supFlag <= (strobe.cause == CAUSE_SUP);
        mcdEn   <= (strobe.cause == CAUSE_MCD);
      end
    end
  end

  always_comb begin
    if (regAddr == REG_MON) rdData = {monEn, supOkS, monLvl, 5'b0};
    else                    rdData = {4'b0, supFlag, mcdEn, monSel, pinFlag};
  end

  assign monLevelHigh = monLvl;
  assign unusedWr = ^{wrData[6], wrData[4:3], wrData[0]};

  // R7: every captured event leaves exactly one cause bit set
  p_one_cause_r7: assert property (@(posedge refClk) disable iff (!porN)
    strobe.latchCause |=> $onehot({pinFlag, supFlag, mcdEn}));
  // R5: the level timer saturates at its limit
  p_mcd_bounded_r5: assert property (@(posedge refClk) disable iff (!porN)
    mcdCnt <= MCD_MAX);
  // R5: a disabled detector keeps its timer cleared
  p_mcd_off_r5: assert property (@(posedge refClk) disable iff (!porN)
    !mcdEn |=> (mcdCnt == '0));
  // R10: read-only cause flags move only on a capture
  p_flags_stable_r10: assert property (@(posedge refClk) disable iff (!porN)
    !strobe.latchCause |=> $stable({pinFlag, supFlag}));
endmodule

// File: rtl/rcc_top.sv
module rcc_top
  import rcc_pkg::*;
#(
  parameter int MCD_LIMIT   = 64,
  parameter int STRETCH_CYC = 16
) (
  input  logic       refClk,
  input  logic       porN,
  input  logic       extRstN,
  input  logic       supplyOk,
  input  logic       sysClk,
  input  logic       wrEn,
  input  logic       regAddr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       monLevelHigh,
  output logic       sysRst
);
  ctlStrobe_t strobe;
  logic pinReq, supReq, mcdReq, stretchDone, holdRst;

  rcc_control control_i (
    .refClk(refClk), .porN(porN), .pinReq(pinReq), .supReq(supReq),
    .mcdReq(mcdReq), .stretchDone(stretchDone), .strobe(strobe),
    .holdRst(holdRst));

  rcc_datapath #(.MCD_LIMIT(MCD_LIMIT), .STRETCH_CYC(STRETCH_CYC)) datapath_i (
    .refClk(refClk), .porN(porN), .extRstN(extRstN), .supplyOk(supplyOk),
    .sysClk(sysClk), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .strobe(strobe), .pinReq(pinReq), .supReq(supReq), .mcdReq(mcdReq),
    .stretchDone(stretchDone), .rdData(rdData), .monLevelHigh(monLevelHigh));

  assign sysRst = ~porN | holdRst;
endmodule

// File: tb/rcc_top_tb_top.sv
`timescale 1ns/1ps
module rcc_top_tb_top;
  localparam int LIM = 6;
  localparam int STR = 4;

  logic refClk = 1'b0;
  logic porN = 1'b0, extRstN = 1'b1, supplyOk = 1'b1, sysClk = 1'b0;
  logic wrEn = 1'b0, regAddr = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic monLevelHigh, sysRst;

  int checks = 0, errors = 0, halfP = 2, hCnt = 0, cycles = 0;
  bit done = 0;

  rcc_top #(.MCD_LIMIT(LIM), .STRETCH_CYC(STR)) dut_i (
    .refClk(refClk), .porN(porN), .extRstN(extRstN), .supplyOk(supplyOk),
    .sysClk(sysClk), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .monLevelHigh(monLevelHigh), .sysRst(sysRst));

  always #4 refClk = ~refClk;

  // system clock: each level lasts halfP reference cycles, 0 = stopped
  always @(negedge refClk) begin
    if (halfP != 0) begin
      if (hCnt >= halfP - 1) begin sysClk <= ~sysClk; hCnt <= 0; end
      else hCnt <= hCnt + 1;
    end
  end

  always @(posedge refClk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog actual %0d expected below 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge refClk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge refClk);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge refClk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge refClk);
    regAddr = a;
    #1 v = rdData;
  endtask

  logic [7:0] v;
  int k;
  bit fired;
  logic pinExp;

  initial begin
    tick(3);
    chk("R1 sysRst during power-on", sysRst, 1);
    porN = 1'b1;
    tick(3);
    chk("R1 sysRst", sysRst, 0);
    rd(1, v); chk("R1 src", v, 8'h00);
    rd(0, v); chk("R1 mon", v, 8'hC0);
    chk("R1 level", monLevelHigh, 0);

    // R8 monitor control layout
    wr(0, 8'hFF); rd(0, v); chk("R8 mon all ones", v, 8'hE0);
    chk("R8 level out", monLevelHigh, 1);
    supplyOk = 1'b0; tick(4);
    rd(0, v); chk("R8 status low", v, 8'hA0);
    chk("R4 not selected", sysRst, 0);
    wr(0, 8'h00); rd(0, v); chk("R8 mon zero", v, 8'h00);
    chk("R8 level out low", monLevelHigh, 0);
    // R4 selected but disabled
    wr(1, 8'h02); tick(6);
    chk("R4 selected not enabled", sysRst, 0);
    wr(0, 8'h80); tick(4);
    chk("R4 enabled and selected", sysRst, 1);
    supplyOk = 1'b1; tick(20);
    chk("R4 release", sysRst, 0);
    rd(1, v); chk("R4 src flags", v, 8'h0A);

    // R2 / R3 pin reset
    wr(1, 8'h06);
    @(negedge refClk); extRstN = 1'b0;
    tick(3); chk("R2 entry", sysRst, 1);
    tick(10); chk("R2 held", sysRst, 1);
    extRstN = 1'b1;
    k = 0;
    for (int i = 0; i < 50; i++) begin
      tick(1);
      if (sysRst) k = k + 1; else break;
    end
    chk("R2 stretch length", k, STR + 2);
    rd(1, v); chk("R3 src after pin", v, 8'h03);
    halfP = 0; tick(3 * LIM + 5);
    chk("R3 detector disabled", sysRst, 0);
    halfP = 2; tick(4);

    // R9 reset-source write mask
    wr(1, 8'hFF); rd(1, v); chk("R9 write ones", v, 8'h07);
    wr(1, 8'h00); rd(1, v); chk("R9 write zeros", v, 8'h01);

    // R10 later request keeps the first cause
    wr(1, 8'h02);
    supplyOk = 1'b0; tick(5);
    chk("R10 supply reset", sysRst, 1);
    extRstN = 1'b0; tick(6); extRstN = 1'b1; tick(5);
    supplyOk = 1'b1; tick(20);
    chk("R10 release", sysRst, 0);
    rd(1, v); chk("R10 cause kept", v, 8'h0A);

    // R7 pin beats supply
    @(negedge refClk); extRstN = 1'b0; supplyOk = 1'b0;
    tick(6); extRstN = 1'b1; supplyOk = 1'b1;
    tick(20); chk("R7 release", sysRst, 0);
    rd(1, v); chk("R7 pin wins", v, 8'h03);
    pinExp = 1'b1;

    // R5 / R6 sweep of system-clock half-periods
    for (int h = 1; h <= LIM + 4; h++) begin
      halfP = 2; tick(10);
      wr(1, 8'h04);
      halfP = h; fired = 0;
      for (int c = 0; c < 3 * h + LIM + 4; c++) begin
        tick(1);
        if (sysRst) fired = 1;
      end
      halfP = 2; tick(LIM + STR + 12);
      chk("R5 recovered", sysRst, 0);
      chk($sformatf("R5 fire at half-period %0d", h), fired, (h > LIM) ? 1 : 0);
      if (fired) pinExp = 1'b0;
      rd(1, v);
      chk($sformatf("R6 src at half-period %0d", h), v, {7'b0000010, pinExp});
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule